// File: doc/BRIEF.md
# Occupancy-Ordered Buffer Write Allocator

This block sits on the ingress side of a cell switch whose buffer is split into several independent memories. In each cell slot it receives a valid bit and a destination output port for every ingress port. It places each arriving cell into its own memory and prefers the memories that currently hold the fewest cells, so that the shared storage fills evenly. It then drives the ingress crosspoint selection for each memory, gives each selected memory a write address, and hands the read side one placement record per stored cell.

Each memory owns a pool of free addresses. The pool is a FIFO that starts with every address in ascending order. A write pops the head address and raises that memory's fill count. A release strobe from the read side pushes an address back and lowers the count. A cell that finds no non-full memory at its turn is discarded, and a running counter records it.

The sequencer has two states. `ST_IDLE` means no slot result is being presented. `ST_ISSUE` means the registered results of the previous cycle's slot are on the outputs. The transition `slot_i=1` leads from either state to `ST_ISSUE`. The transition `slot_i=0` leads from either state to `ST_IDLE`.

Top module: `occ_write_alloc`

## Requirements
- R1: After reset, every memory is empty and its pool holds addresses 0 to DEPTH-1 in ascending order. No record or write strobe is asserted, and `drop_cnt_o` is 0.
- R2: Results of a slot appear in the cycle after the cycle in which `slot_i` is high. In any cycle that follows a cycle with `slot_i` low, `rec_vld_o` and `mem_we_o` are all zero.
- R3: Valid inputs are ranked by index, lowest first. The valid input at position p in that ranking is placed in the non-full memory that has rank p. A memory's rank is the number of non-full memories that hold fewer cells than it, or the same number of cells with a lower index. Fill levels are those before the slot.
- R4: When two memories hold the same number of cells, the lower-numbered memory ranks first.
- R5: In a slot, each input is connected to at most one memory and each memory to at most one input. `mem_we_o[m]` is high exactly when some record names memory m. `mem_src_o` field m, at bits [m*IW +: IW], then gives that input's index.
- R6: A memory holding DEPTH cells is never chosen. A valid input whose ranking position is at or above the number of non-full memories is dropped, and `drop_cnt_o` rises by one for each such cell.
- R7: The write address given to a memory is the head of its free pool. `rec_addr_o` field k, at bits [k*AW +: AW], equals `mem_waddr_o` of the chosen memory.
- R8: A release on `rel_en_i[m]` with address `rel_addr_i[m*AW +: AW]` returns that address to the tail of memory m's pool. It lowers that memory's fill count for later slots.
- R9: `rec_mem_o` field k, at bits [k*MW +: MW], gives the chosen memory. `rec_dst_o` field k, at bits [k*DST_W +: DST_W], repeats the destination presented on `cell_dst_i` for input k.
- R10: `cell_vld_i` has no effect while `slot_i` is low: no record, no write strobe, and no change to fill levels or pools.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | Cell slot strobe |
| cell_vld_i | input | N_IN | Arriving cell present, one bit per input |
| cell_dst_i | input | N_IN*DST_W | Destination output per input |
| rel_en_i | input | N_MEM | Address release strobe per memory |
| rel_addr_i | input | N_MEM*AW | Released address per memory |
| rec_vld_o | output | N_IN | Placement record valid per input |
| rec_mem_o | output | N_IN*MW | Memory chosen per input |
| rec_addr_o | output | N_IN*AW | Address inside the chosen memory |
| rec_dst_o | output | N_IN*DST_W | Destination output carried in the record |
| mem_we_o | output | N_MEM | Write strobe per memory |
| mem_src_o | output | N_MEM*IW | Crosspoint select: input feeding each memory |
| mem_waddr_o | output | N_MEM*AW | Write address per memory |
| drop_cnt_o | output | DROP_W | Running count of discarded cells |

## Verification
The first directed slot has every input valid while all memories are empty. This isolates the tie rule, because the only correct result is memories 0 to 3 in input order. A sparse slot with inputs 1 and 3 follows, which shows that ranking position rather than input index selects the memory. An all-valid burst then fills every memory, so it exercises full-memory skipping and drop counting. A single release lets one memory take exactly one cell with its returned address. Seeded random slots with mixed releases then exercise uneven fill levels, where a wrong comparison or a wrong tie rule gives a different memory choice.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } slot_state_e;
endpackage

// File: rtl/occ_rank.sv
// Ranks every non-full memory by fill level; ties broken toward lower index.
module occ_rank #(
    parameter int N_MEM = 8,
    parameter int CW    = 5,
    parameter int MW    = 3
) (
    input  logic [N_MEM*CW-1:0] occ_flat,
    input  logic [N_MEM-1:0]    full,
    output logic [N_MEM*MW-1:0] rank_flat
);
    logic [CW-1:0] occ [N_MEM];
    logic [MW-1:0] rank [N_MEM];

    for (genvar g = 0; g < N_MEM; g++) begin : g_unpack
        assign occ[g] = occ_flat[g*CW +: CW];
        assign rank_flat[g*MW +: MW] = rank[g];
    end

    always_comb begin
        for (int m = 0; m < N_MEM; m++) begin
            rank[m] = '0;
            for (int j = 0; j < N_MEM; j++) begin
                if (!full[j] && (j != m) &&
                    ((occ[j] < occ[m]) || ((occ[j] == occ[m]) && (j < m)))) begin
                    rank[m] = rank[m] + MW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/mem_pool.sv
// Free-address FIFO and fill count for one buffer memory. DEPTH must be a power of two.
module mem_pool #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] head_addr,
    output logic [CW-1:0] occ,
    output logic          full
);
    logic [AW-1:0] slots [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;

    assign head_addr = slots[rd_ptr];
    assign full      = (occ == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= AW'(i);
            end
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            if (pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            if (push) begin
                slots[wr_ptr] <= push_addr;
                wr_ptr        <= wr_ptr + AW'(1);
            end
            if (pop && !push) begin
                occ <= occ + CW'(1);
            end else if (push && !pop) begin
                occ <= occ - CW'(1);
            end
        end
    end

    // R6: a full memory never hands out an address
    a_r6_no_pop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !full);

    // R8: a release only returns an address that was in use
    a_r8_release_needs_cell: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (occ != '0));
endmodule

// File: rtl/occ_write_alloc.sv
module occ_write_alloc
    import alloc_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_MEM  = 8,
    parameter int DEPTH  = 16,
    parameter int DST_W  = 3,
    parameter int DROP_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              slot_i,
    input  logic [N_IN-1:0]                   cell_vld_i,
    input  logic [N_IN*DST_W-1:0]             cell_dst_i,
    input  logic [N_MEM-1:0]                  rel_en_i,
    input  logic [N_MEM*$clog2(DEPTH)-1:0]    rel_addr_i,
    output logic [N_IN-1:0]                   rec_vld_o,
    output logic [N_IN*$clog2(N_MEM)-1:0]     rec_mem_o,
    output logic [N_IN*$clog2(DEPTH)-1:0]     rec_addr_o,
    output logic [N_IN*DST_W-1:0]             rec_dst_o,
    output logic [N_MEM-1:0]                  mem_we_o,
    output logic [N_MEM*$clog2(N_IN)-1:0]     mem_src_o,
    output logic [N_MEM*$clog2(DEPTH)-1:0]    mem_waddr_o,
    output logic [DROP_W-1:0]                 drop_cnt_o
);
    localparam int MW  = $clog2(N_MEM);
    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int IW  = $clog2(N_IN);
    localparam int OW  = MW + 1;
    localparam int NCW = $clog2(N_IN + 1);

    // ---------------- per-memory pools ----------------
    logic [CW-1:0]       occ  [N_MEM];
    logic [AW-1:0]       head [N_MEM];
    logic [N_MEM-1:0]    full;
    logic [N_MEM-1:0]    pop;
    logic [N_MEM*CW-1:0] occ_flat;
    logic [N_MEM*MW-1:0] rank_flat;
    logic [MW-1:0]       rank [N_MEM];

    for (genvar m = 0; m < N_MEM; m++) begin : g_pool
        mem_pool #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_pool (
            .clk      (clk),
            .rst_n    (rst_n),
            .pop      (pop[m]),
            .push     (rel_en_i[m]),
            .push_addr(rel_addr_i[m*AW +: AW]),
            .head_addr(head[m]),
            .occ      (occ[m]),
            .full     (full[m])
        );
        assign occ_flat[m*CW +: CW] = occ[m];
        assign rank[m] = rank_flat[m*MW +: MW];
    end

    occ_rank #(.N_MEM(N_MEM), .CW(CW), .MW(MW)) u_rank (
        .occ_flat (occ_flat),
        .full     (full),
        .rank_flat(rank_flat)
    );

    // ---------------- pairing of inputs with ranked memories ----------------
    logic [OW-1:0]  ord  [N_IN];
    logic [N_IN-1:0] got;
    logic [MW-1:0]  gmem [N_IN];
    logic [IW-1:0]  src  [N_MEM];
    logic [NCW-1:0] ndrop;

    always_comb begin
        ord[0] = '0;
        for (int k = 1; k < N_IN; k++) begin
            ord[k] = ord[k-1] + OW'(cell_vld_i[k-1]);
        end
        pop = '0;
        got = '0;
        for (int k = 0; k < N_IN; k++) begin
            gmem[k] = '0;
        end
        for (int m = 0; m < N_MEM; m++) begin
            src[m] = '0;
            for (int k = 0; k < N_IN; k++) begin
                if (slot_i && cell_vld_i[k] && !full[m] && (ord[k] == {1'b0, rank[m]})) begin
                    pop[m]  = 1'b1;
                    src[m]  = IW'(k);
                    got[k]  = 1'b1;
                    gmem[k] = MW'(m);
                end
            end
        end
        ndrop = '0;
        for (int k = 0; k < N_IN; k++) begin
            if (slot_i && cell_vld_i[k] && !got[k]) begin
                ndrop = ndrop + NCW'(1);
            end
        end
    end

    // ---------------- slot sequencer ----------------
    slot_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = slot_i ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = slot_i ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- output registers ----------------
    logic [N_IN-1:0]   rec_vld_q;
    logic [MW-1:0]     rec_mem_q  [N_IN];
    logic [AW-1:0]     rec_addr_q [N_IN];
    logic [DST_W-1:0]  rec_dst_q  [N_IN];
    logic [N_MEM-1:0]  we_q;
    logic [IW-1:0]     src_q      [N_MEM];
    logic [AW-1:0]     waddr_q    [N_MEM];
    logic [DROP_W-1:0] drop_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_vld_q <= '0;
            we_q      <= '0;
            drop_q    <= '0;
            for (int k = 0; k < N_IN; k++) begin
                rec_mem_q[k]  <= '0;
                rec_addr_q[k] <= '0;
                rec_dst_q[k]  <= '0;
            end
            for (int m = 0; m < N_MEM; m++) begin
                src_q[m]   <= '0;
                waddr_q[m] <= '0;
            end
        end else begin
            rec_vld_q <= got;
            we_q      <= pop;
            drop_q    <= drop_q + DROP_W'(ndrop);
            for (int k = 0; k < N_IN; k++) begin
                rec_mem_q[k]  <= gmem[k];
                rec_addr_q[k] <= head[gmem[k]];
                rec_dst_q[k]  <= cell_dst_i[k*DST_W +: DST_W];
            end
            for (int m = 0; m < N_MEM; m++) begin
                src_q[m]   <= src[m];
                waddr_q[m] <= head[m];
            end
        end
    end

    always_comb begin
        rec_vld_o  = (state_q == ST_ISSUE) ? rec_vld_q : '0;
        mem_we_o   = (state_q == ST_ISSUE) ? we_q : '0;
        drop_cnt_o = drop_q;
    end

    for (genvar k = 0; k < N_IN; k++) begin : g_rec
        assign rec_mem_o[k*MW +: MW]        = rec_mem_q[k];
        assign rec_addr_o[k*AW +: AW]       = rec_addr_q[k];
        assign rec_dst_o[k*DST_W +: DST_W]  = rec_dst_q[k];

        // R5: a record names a memory that is strobed and fed from this input
        a_r5_rec_matches_xbar: assert property (@(posedge clk) disable iff (!rst_n)
            rec_vld_o[k] |-> (mem_we_o[rec_mem_q[k]] && (src_q[rec_mem_q[k]] == IW'(k))));

        // R7: record address equals the address driven to that memory
        a_r7_addr_matches: assert property (@(posedge clk) disable iff (!rst_n)
            rec_vld_o[k] |-> (waddr_q[rec_mem_q[k]] == rec_addr_q[k]));
    end

    for (genvar m = 0; m < N_MEM; m++) begin : g_mem
        assign mem_src_o[m*IW +: IW]   = src_q[m];
        assign mem_waddr_o[m*AW +: AW] = waddr_q[m];
    end

    // R2: nothing is presented after a cycle without a slot strobe
    a_r2_quiet_without_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_i |=> ((rec_vld_o == '0) && (mem_we_o == '0)));

    // R5: one write strobe per record
    a_r5_we_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_we_o) == $countones(rec_vld_o));
endmodule

// File: tb/occ_write_alloc_test.sv
`timescale 1ns/1ps
module occ_write_alloc_test;
    localparam int NI  = 4;
    localparam int NM  = 8;
    localparam int DEP = 16;
    localparam int DW  = 3;
    localparam int MW  = 3;
    localparam int AW  = 4;
    localparam int IW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_i = 1'b0;
    logic [NI-1:0]    cell_vld_i = '0;
    logic [NI*DW-1:0] cell_dst_i = '0;
    logic [NM-1:0]    rel_en_i = '0;
    logic [NM*AW-1:0] rel_addr_i = '0;
    logic [NI-1:0]    rec_vld_o;
    logic [NI*MW-1:0] rec_mem_o;
    logic [NI*AW-1:0] rec_addr_o;
    logic [NI*DW-1:0] rec_dst_o;
    logic [NM-1:0]    mem_we_o;
    logic [NM*IW-1:0] mem_src_o;
    logic [NM*AW-1:0] mem_waddr_o;
    logic [15:0]      drop_cnt_o;

    always #4 clk = ~clk;

    occ_write_alloc uut (
        .clk(clk), .rst_n(rst_n), .slot_i(slot_i),
        .cell_vld_i(cell_vld_i), .cell_dst_i(cell_dst_i),
        .rel_en_i(rel_en_i), .rel_addr_i(rel_addr_i),
        .rec_vld_o(rec_vld_o), .rec_mem_o(rec_mem_o), .rec_addr_o(rec_addr_o),
        .rec_dst_o(rec_dst_o), .mem_we_o(mem_we_o), .mem_src_o(mem_src_o),
        .mem_waddr_o(mem_waddr_o), .drop_cnt_o(drop_cnt_o)
    );

    int checks = 0;
    int failures = 0;

    int occ_m [NM];
    int fq    [NM][DEP];
    int fh    [NM];
    int ft    [NM];
    bit used  [NM][DEP];
    int drops_exp = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rank_of(input int m);
        int r = 0;
        for (int j = 0; j < NM; j++) begin
            if (occ_m[j] < DEP && j != m &&
                (occ_m[j] < occ_m[m] || (occ_m[j] == occ_m[m] && j < m)))
                r++;
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int m = 0; m < NM; m++) begin
            occ_m[m] = 0; fh[m] = 0; ft[m] = 0;
            for (int a = 0; a < DEP; a++) begin
                fq[m][a] = a; used[m][a] = 1'b0;
            end
        end
        drops_exp = 0;
    endtask

    task automatic run_slot(input logic [NI-1:0] v, input logic [NI*DW-1:0] d,
                            input logic [NM-1:0] rel_req, input string tag);
        bit e_vld [NI];
        int e_mem [NI];
        int e_addr [NI];
        bit e_we [NM];
        int e_src [NM];
        int e_wa [NM];
        logic [NM-1:0]    rel;
        logic [NM*AW-1:0] ra;
        int ord;
        @(negedge clk);
        chk("R2 quiet before slot", int'(rec_vld_o), 0);
        rel = '0; ra = '0;
        for (int m = 0; m < NM; m++) begin
            e_we[m] = 0; e_src[m] = 0; e_wa[m] = 0;
            if (rel_req[m] && occ_m[m] > 0) begin
                for (int a = DEP - 1; a >= 0; a--) begin
                    if (used[m][a]) ra[m*AW +: AW] = AW'(a);
                end
                rel[m] = 1'b1;
            end
        end
        ord = 0;
        for (int k = 0; k < NI; k++) begin
            e_vld[k] = 0; e_mem[k] = 0; e_addr[k] = 0;
            if (v[k]) begin
                for (int m = 0; m < NM; m++) begin
                    if (occ_m[m] < DEP && rank_of(m) == ord) begin
                        e_vld[k] = 1; e_mem[k] = m; e_addr[k] = fq[m][fh[m]];
                        e_we[m] = 1; e_src[m] = k; e_wa[m] = e_addr[k];
                    end
                end
                if (!e_vld[k]) drops_exp++;
                ord++;
            end
        end
        slot_i = 1'b1; cell_vld_i = v; cell_dst_i = d;
        rel_en_i = rel; rel_addr_i = ra;
        for (int m = 0; m < NM; m++) begin
            if (e_we[m]) begin
                fh[m] = (fh[m] + 1) % DEP; occ_m[m]++; used[m][e_wa[m]] = 1'b1;
            end
        end
        for (int m = 0; m < NM; m++) begin
            if (rel[m]) begin
                used[m][int'(ra[m*AW +: AW])] = 1'b0;
                fq[m][ft[m]] = int'(ra[m*AW +: AW]);
                ft[m] = (ft[m] + 1) % DEP; occ_m[m]--;
            end
        end
        @(negedge clk);
        slot_i = 1'b0; cell_vld_i = '0; rel_en_i = '0; rel_addr_i = '0;
        for (int k = 0; k < NI; k++) begin
            chk({tag, " record valid"}, int'(rec_vld_o[k]), int'(e_vld[k]));
            if (e_vld[k]) begin
                chk({tag, " memory choice"}, int'(rec_mem_o[k*MW +: MW]), e_mem[k]);
                chk("R7 record address", int'(rec_addr_o[k*AW +: AW]), e_addr[k]);
                chk("R9 record destination", int'(rec_dst_o[k*DW +: DW]), int'(d[k*DW +: DW]));
            end
        end
        for (int m = 0; m < NM; m++) begin
            chk("R5 write strobe", int'(mem_we_o[m]), int'(e_we[m]));
            if (e_we[m]) begin
                chk("R5 crosspoint source", int'(mem_src_o[m*IW +: IW]), e_src[m]);
                chk("R7 write address", int'(mem_waddr_o[m*AW +: AW]), e_wa[m]);
            end
        end
        chk("R6 drop count", int'(drop_cnt_o), drops_exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 no records", int'(rec_vld_o), 0);
        chk("R1 no strobes", int'(mem_we_o), 0);
        chk("R1 drop count", int'(drop_cnt_o), 0);

        // R4: all memories tied at zero -> memories 0..3, address 0
        run_slot(4'b1111, 12'o7531, 8'h00, "R4");
        // R3: sparse inputs use ranking position, not input index
        run_slot(4'b1010, 12'o1234, 8'h00, "R3");

        // R10: valid without slot strobe is ignored
        @(negedge clk);
        cell_vld_i = 4'b1111;
        @(negedge clk);
        cell_vld_i = '0;
        chk("R10 no record without slot", int'(rec_vld_o), 0);
        chk("R10 no strobe without slot", int'(mem_we_o), 0);
        run_slot(4'b0001, 12'o0006, 8'h00, "R10");

        // R6: fill every memory, then drops
        for (int s = 0; s < 36; s++) begin
            run_slot(4'b1111, NI*DW'($urandom), 8'h00, "R6");
        end
        // R8: release one address on memory 5, then it takes exactly one cell
        run_slot(4'b0000, '0, 8'b0010_0000, "R8");
        run_slot(4'b1111, 12'o4321, 8'h00, "R8");

        // random mix
        for (int s = 0; s < 400; s++) begin
            run_slot(NI'($urandom), NI*DW'($urandom), NM'($urandom & $urandom), "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule